// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This block clears or paints regions of memory with a fixed 32-bit pattern, without the processor having to touch every word. It holds two independent fill channels behind a small 32-bit register window. Software programs a channel's start address and end address, then writes the pattern. Writing the pattern is the start command. The engine walks the range one word at a time and presents each word on a memory write port with a valid/ready handshake. When the range is done, the engine raises a one-cycle interrupt on that channel's own line.

Only one word is written per accepted beat, so the two channels share a single sequencer. If both channels are waiting, channel 0 goes first. A start command that arrives while its channel is still waiting or running is remembered, and that channel runs again afterwards. Each channel samples its start, end and pattern at the moment its run begins. A start address of zero means the channel is unconfigured, so the start command is dropped.

Top module: `fill_engine`

## Requirements
- R1: The register index is (addr_i - 0x1EF00000) / 4. Index 3c holds channel c's start byte address, 3c+1 its end byte address and 3c+2 its pattern. Index 6 is a read-only status word: bit 0 is channel 0 busy and bit 1 is channel 1 busy. A read returns the stored value on rdata_o in the cycle after the request.
- R2: An access is accepted only if size_i is 2 (word; 0 is byte, 1 is halfword, 3 is doubleword), the offset is word aligned and the index is below 7. A rejected write changes nothing. A rejected read returns zero.
- R3: An accepted write to channel c's pattern register starts a fill on channel c.
- R4: If channel c's start register is zero when its pattern is written, no fill runs and no interrupt is raised.
- R5: A fill writes every word address start, start+4, ... that is strictly below end. If start >= end, no word is written, but the completion interrupt is still raised.
- R6: Each stored word is the pattern with its byte order reversed (0x11223344 is stored as 0x44332211).
- R7: Each completed fill gives exactly one one-cycle pulse on irq_o[c] for its own channel, and never on both lines in the same cycle.
- R8: When both channels are waiting and the engine is free, channel 0 is served first.
- R9: A channel is busy from its start command until its completion. A start command that arrives while the channel is busy is held, and that channel runs once more afterwards.
- R10: While mem_valid_o is high and mem_ready_i is low, mem_addr_o and mem_data_o hold their values. The address advances by exactly one word for each accepted beat.
- R11: Start, end and pattern are sampled when a run begins. Writes to them during the run do not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Register byte address |
| size_i | input | 2 | Access size code (2 = word) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, one cycle after the request |
| mem_valid_o | output | 1 | Memory write word valid |
| mem_ready_i | input | 1 | Memory accepts the word |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_data_o | output | 32 | Memory write data |
| irq_o | output | 2 | Per-channel completion pulse |

## Verification
The assertions watch, on every cycle, the following rules:
- the write port holds its address and data under backpressure;
- only aligned addresses are issued;
- a memory write happens only while some channel is busy;
- interrupts are single-cycle, mutually exclusive and come only from a busy channel.

Some behaviour can only be shown by the directed scenarios, because it needs a reference for the expected result:
- the exact address sequence and its end-exclusive bound;
- the byte-swapped data;
- channel 0 winning a tie;
- a latched rerun;
- the zero-start suppression;
- rejected accesses leaving the registers untouched;
- the sampling of the configuration when a run begins.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam logic [31:0] WIN_BASE    = 32'h1EF0_0000;
  localparam int          REGS_PER_CH = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [31:0] start_a;
    logic [31:0] end_a;
    logic [31:0] pattern;
  } fill_cfg_t;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] take_i,
  output logic [31:0]       rdata_o,
  output fill_cfg_t         cfg_o [NUM_CH],
  output logic [NUM_CH-1:0] pend_o
);
  localparam int          NUM_REGS = REGS_PER_CH * NUM_CH + 1;
  localparam logic [29:0] STAT_IDX = 30'(REGS_PER_CH * NUM_CH);

  logic [31:0] off;
  logic [29:0] idx;
  logic        hit, wr_hit;
  logic [31:0] rd_mux;

  assign off    = addr_i - WIN_BASE;
  assign idx    = off[31:2];
  assign hit    = req_i && (size_i == SZ_WORD) && (off[1:0] == 2'b00) && (idx < 30'(NUM_REGS));
  assign wr_hit = hit && we_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [29:0] I_START = 30'(c * REGS_PER_CH);
    localparam logic [29:0] I_END   = 30'(c * REGS_PER_CH + 1);
    localparam logic [29:0] I_PAT   = 30'(c * REGS_PER_CH + 2);
    logic trig;

    // start command only counts when the channel has a non-zero start address
    assign trig = wr_hit && (idx == I_PAT) && (cfg_o[c].start_a != 32'd0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[c]  <= '0;
        pend_o[c] <= 1'b0;
      end else begin
        if (wr_hit && idx == I_START) cfg_o[c].start_a <= wdata_i;
        if (wr_hit && idx == I_END)   cfg_o[c].end_a   <= wdata_i;
        if (wr_hit && idx == I_PAT)   cfg_o[c].pattern <= wdata_i;
        pend_o[c] <= (pend_o[c] & ~take_i[c]) | trig;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (idx == STAT_IDX) rd_mux = 32'(busy_i);
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == 30'(c * REGS_PER_CH))     rd_mux = cfg_o[c].start_a;
      if (idx == 30'(c * REGS_PER_CH + 1)) rd_mux = cfg_o[c].end_a;
      if (idx == 30'(c * REGS_PER_CH + 2)) rd_mux = cfg_o[c].pattern;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= hit ? rd_mux : 32'd0;
  end
endmodule

// File: rtl/fill_arb.sv
module fill_arb #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic              idle_i,
  output logic [NUM_CH-1:0] take_o,
  output logic [CH_W-1:0]   sel_o
);
  // lowest channel number wins
  always_comb begin
    sel_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) sel_o = CH_W'(i);
    end
    take_o = '0;
    if (idle_i && (|pend_i)) take_o[sel_o] = 1'b1;
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   sel_i,
  input  fill_cfg_t         cfg_i [NUM_CH],
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] run_o,
  output logic              idle_o
);
  logic            active;
  logic [CH_W-1:0] ch;
  logic [32:0]     cur;   // extra bit stops wrap at the top of the address space
  logic [31:0]     lim;
  logic [31:0]     pat;
  logic            more;

  assign more        = cur < {1'b0, lim};
  assign idle_o      = !active;
  assign mem_valid_o = active && more;
  assign mem_addr_o  = cur[31:0];
  assign mem_data_o  = bswap32(pat);

  always_comb begin
    run_o = '0;
    if (active) run_o[ch] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      ch     <= '0;
      cur    <= '0;
      lim    <= '0;
      pat    <= '0;
      irq_o  <= '0;
    end else begin
      irq_o <= '0;
      if (!active) begin
        if (start_i) begin
          active <= 1'b1;
          ch     <= sel_i;
          cur    <= {1'b0, cfg_i[sel_i].start_a[31:2], 2'b00};
          lim    <= cfg_i[sel_i].end_a;
          pat    <= cfg_i[sel_i].pattern;
        end
      end else if (more) begin
        if (mem_ready_i) cur <= cur + 33'd4;
      end else begin
        active    <= 1'b0;
        irq_o[ch] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  fill_cfg_t         cfg [NUM_CH];
  logic [NUM_CH-1:0] pend, take, run, busy_w;
  logic [CH_W-1:0]   sel;
  logic              idle;

  assign busy_w = pend | run;

  fill_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .busy_i(busy_w), .take_i(take), .rdata_o, .cfg_o(cfg), .pend_o(pend)
  );

  fill_arb #(.NUM_CH(NUM_CH)) u_arb (
    .pend_i(pend), .idle_i(idle), .take_o(take), .sel_o(sel)
  );

  fill_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i, .rst_ni, .start_i(|take), .sel_i(sel), .cfg_i(cfg),
    .mem_ready_i, .mem_valid_o, .mem_addr_o, .mem_data_o,
    .irq_o, .run_o(run), .idle_o(idle)
  );
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_valid_i,
  input logic              mem_ready_i,
  input logic [31:0]       mem_addr_i,
  input logic [31:0]       mem_data_i,
  input logic [NUM_CH-1:0] irq_i,
  input logic [NUM_CH-1:0] busy_i
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !mem_ready_i |=> mem_valid_i && $stable(mem_addr_i) && $stable(mem_data_i)); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |-> mem_addr_i[1:0] == 2'b00); // R5

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_i)); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |=> !(|irq_i)); // R7

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |-> (|busy_i)); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    AST_IRQ_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> $past(busy_i[c])); // R7
  end
endmodule

bind fill_engine fill_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_valid_i(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_i(mem_addr_o), .mem_data_i(mem_data_o), .irq_i(irq_o), .busy_i(busy_w)
);

// File: tb/fill_engine_test.sv
module fill_engine_test;
  localparam logic [31:0] B  = 32'h1EF0_0000;
  localparam logic [31:0] S0 = B + 32'h00, E0 = B + 32'h04, V0 = B + 32'h08;
  localparam logic [31:0] S1 = B + 32'h0C, E1 = B + 32'h10, V1 = B + 32'h14;
  localparam logic [31:0] ST = B + 32'h18;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0;
  logic [31:0] addr_i = 0, wdata_i = 0;
  logic [1:0]  size_i = 2'd2;
  logic [31:0] rdata_o, mem_addr_o, mem_data_o;
  logic        mem_valid_o, mem_ready_i;
  logic [1:0]  irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ready_mode = 0;  // 0 always ready, 1 alternate, 2 stalled
  logic [31:0] log_a [0:63];
  logic [31:0] log_d [0:63];
  int log_n = 0;
  int irq_cnt [2] = '{0, 0};

  always #10 clk = ~clk;

  fill_engine uut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i, .rdata_o,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o, .irq_o
  );

  initial mem_ready_i = 1'b1;
  always @(negedge clk) begin
    case (ready_mode)
      0: mem_ready_i = 1'b1;
      1: mem_ready_i = ~mem_ready_i;
      default: mem_ready_i = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_ni && mem_valid_o && mem_ready_i && log_n < 64) begin
      log_a[log_n] = mem_addr_o;
      log_d[log_n] = mem_data_o;
      log_n++;
    end
    if (rst_ni && irq_o[0]) irq_cnt[0]++;
    if (rst_ni && irq_o[1]) irq_cnt[1]++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; size_i = sz;
    @(negedge clk);
    req_i = 0; we_i = 0; size_i = 2'd2;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a; size_i = sz;
    @(negedge clk);
    req_i = 0; size_i = 2'd2;
    d = rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(ST, s);
      if (s[1:0] == 2'b00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_run(input int from, input logic [31:0] a0, input int n,
                         input logic [31:0] d, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(log_a[from+i] == a0 + 32'(4*i), {tag, " addr"}, log_a[from+i], a0 + 32'(4*i));
      chk(log_d[from+i] == d, {tag, " data"}, log_d[from+i], d);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(mem_valid_o == 0, "R1 reset valid", 32'(mem_valid_o), 0);
    chk(irq_o == 0, "R7 reset irq", 32'(irq_o), 0);
    rd(ST, v);  chk(v == 0, "R1 reset status", v, 0);
    rd(S0, v);  chk(v == 0, "R1 reset start", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int n0 = log_n, i0 = irq_cnt[0];
    wr(S0, 32'h100); wr(E0, 32'h110);
    rd(S0, v); chk(v == 32'h100, "R1 readback start", v, 32'h100);
    rd(E0, v); chk(v == 32'h110, "R1 readback end", v, 32'h110);
    wr(V0, 32'h1122_3344);
    wait_idle();
    chk(log_n - n0 == 4, "R5 R3 word count", 32'(log_n - n0), 4);
    chk_run(n0, 32'h100, 4, 32'h4433_2211, "R6 R5 basic");
    chk(irq_cnt[0] - i0 == 1, "R7 irq0 once", 32'(irq_cnt[0] - i0), 1);
    chk(irq_cnt[1] == 0, "R7 irq1 silent", 32'(irq_cnt[1]), 0);
    rd(V0, v); chk(v == 32'h1122_3344, "R1 readback pattern", v, 32'h1122_3344);
  endtask

  task automatic t_ch1_throttled();
    int n0 = log_n, i1 = irq_cnt[1];
    ready_mode = 1;
    wr(S1, 32'h2000); wr(E1, 32'h200C); wr(V1, 32'hA5B6_C7D8);
    wait_idle();
    ready_mode = 0;
    chk(log_n - n0 == 3, "R10 one word per beat", 32'(log_n - n0), 3);
    chk_run(n0, 32'h2000, 3, 32'hD8C7_B6A5, "R10 R6 ch1");
    chk(irq_cnt[1] - i1 == 1, "R7 irq1 once", 32'(irq_cnt[1] - i1), 1);
  endtask

  task automatic t_zero_start();
    logic [31:0] v;
    int n0 = log_n, i0 = irq_cnt[0];
    wr(S0, 32'h0); wr(E0, 32'h40); wr(V0, 32'hDEAD_BEEF);
    rd(ST, v); chk(v == 0, "R4 not busy", v, 0);
    repeat (20) @(negedge clk);
    chk(log_n == n0, "R4 no writes", 32'(log_n - n0), 0);
    chk(irq_cnt[0] == i0, "R4 no irq", 32'(irq_cnt[0] - i0), 0);
  endtask

  task automatic t_empty_range();
    int n0 = log_n, i0 = irq_cnt[0];
    wr(S0, 32'h300); wr(E0, 32'h300); wr(V0, 32'h1);
    wait_idle();
    chk(log_n == n0, "R5 empty no writes", 32'(log_n - n0), 0);
    chk(irq_cnt[0] - i0 == 1, "R5 empty irq", 32'(irq_cnt[0] - i0), 1);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    int n0 = log_n, i0 = irq_cnt[0];
    wr(S0, 32'h400); wr(E0, 32'h408); wr(V0, 32'h0000_0055);
    wait_idle();
    n0 = log_n; i0 = irq_cnt[0];
    wr(V0, 32'h7777_7777, 2'd1);
    wr(S0, 32'h9999_0000, 2'd3);
    wr(S0 + 32'h1, 32'h9999_0000);
    wr(B - 32'h4, 32'h1234);
    wr(B + 32'h1C, 32'h1234);
    repeat (10) @(negedge clk);
    chk(log_n == n0, "R2 no fill", 32'(log_n - n0), 0);
    chk(irq_cnt[0] == i0, "R2 no irq", 32'(irq_cnt[0] - i0), 0);
    rd(V0, v); chk(v == 32'h55, "R2 pattern kept", v, 32'h55);
    rd(S0, v); chk(v == 32'h400, "R2 start kept", v, 32'h400);
    rd(S0, v, 2'd0); chk(v == 0, "R2 byte read zero", v, 0);
    rd(B + 32'h1C, v); chk(v == 0, "R2 out of range read", v, 0);
  endtask

  task automatic t_prio_rerun();
    logic [31:0] v;
    int n0 = log_n, i0 = irq_cnt[0], i1 = irq_cnt[1];
    ready_mode = 2;
    wr(S0, 32'h100); wr(E0, 32'h108); wr(V0, 32'h0A0B_0C0D);
    wr(S1, 32'h2000); wr(E1, 32'h2004); wr(V1, 32'h0102_0304);
    wr(V0, 32'h0A0B_0C0D);
    chk(mem_valid_o && mem_addr_o == 32'h100, "R10 held addr", mem_addr_o, 32'h100);
    rd(ST, v); chk(v[1:0] == 2'b11, "R9 both busy", v, 3);
    // late config writes must not touch the run in progress
    wr(E0, 32'h10C);
    ready_mode = 0;
    wait_idle();
    chk(log_n - n0 == 6, "R8 R9 total words", 32'(log_n - n0), 6);
    chk_run(n0, 32'h100, 2, 32'h0D0C_0B0A, "R11 R8 first ch0");
    chk_run(n0 + 2, 32'h100, 3, 32'h0D0C_0B0A, "R9 R8 rerun ch0");
    chk_run(n0 + 5, 32'h2000, 1, 32'h0403_0201, "R8 ch1 last");
    chk(irq_cnt[0] - i0 == 2, "R9 irq0 twice", 32'(irq_cnt[0] - i0), 2);
    chk(irq_cnt[1] - i1 == 1, "R8 irq1 once", 32'(irq_cnt[1] - i1), 1);
  endtask

  task automatic t_capture();
    int n0 = log_n;
    ready_mode = 2;
    wr(S0, 32'h500); wr(E0, 32'h508); wr(V0, 32'hCAFE_F00D);
    wr(S0, 32'h900); wr(E0, 32'h990);
    ready_mode = 0;
    wait_idle();
    chk(log_n - n0 == 2, "R11 count", 32'(log_n - n0), 2);
    chk_run(n0, 32'h500, 2, 32'h0DF0_FECA, "R11 captured");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ch1_throttled();
    t_zero_start();
    t_empty_range();
    t_reject();
    t_prio_rerun();
    t_capture();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule